// File: doc/BRIEF.md
# Power-Management Function Configuration Slice with APM Command Decoder

This block holds the configuration registers of a power-management function on a PCI-style configuration space and derives two relocatable I/O windows from them. One is a 64-byte power-management window and the other an SMBus window. Each window has a base address that is taken from a 32-bit configuration word. The low six address bits of that word are cleared, and each window has its own enable bit in a separate configuration byte. Configuration accesses are dword-addressed with four byte enables. Reads are combinational and return the stored bytes.

The block also decodes writes to the APM control port. Two command codes switch ACPI mode: 0xF1 turns the SCI-enable control bit on and 0xF0 turns it off. Neither of these raises an SMI. Every other command code produces a one-cycle SMI request, but only when the SMI-enable configuration bit is set. A build parameter says whether SMM is supported. Without SMM, the SMI-enable bit comes out of reset already set, which marks SMM as initialised.

Top module: `pmcfg_top`

## Requirements
- R1: After reset, reads return these dwords: 0x00000001 at offset 0x40, 0x00000000 at 0x58 (SMM supported), 0x00000000 at 0x80, {16'h0, SMB_RESET_BASE with bit 0 set} at 0x90, and 0x00090000 at 0xD0. pm_en is 0, pm_base is 0, smb_en is 1, smb_base is SMB_RESET_BASE & 0xFFC0, sci_en is 0 and smi_pulse is 0.
- R2: A configuration write to offsets 0x40, 0x58 or 0x90 updates exactly the bytes whose byte enable is 1 (cfg_be[k] selects bits 8k+7:8k). All other bytes keep their value.
- R3: Bit 0 of offset 0x40 always reads as 1, whatever is written to it.
- R4: pm_base equals bits 15:0 of the dword at 0x40 ANDed with 0xFFC0. pm_en equals bit 0 of byte 0x80. Both take their new value on the clock edge that stores the configuration write.
- R5: smb_base equals bits 15:0 of the dword at 0x90 ANDed with 0xFFC0. smb_en equals bit 0 of byte 0xD2, which is bit 16 of the dword at 0xD0 and is written under cfg_be[2]. Both update on the same edge as the write.
- R6: When SMM_SUPPORTED is 0, byte 0x5B resets to 0x02, so offset 0x58 reads 0x02000000.
- R7: An APM write of 0xF1 sets sci_en and an APM write of 0xF0 clears it, in the cycle after the write. Other APM codes leave sci_en unchanged. Neither 0xF0 nor 0xF1 raises smi_pulse.
- R8: An APM write of any code other than 0xF0 or 0xF1 drives smi_pulse high for exactly the one cycle after the write, if and only if bit 1 of byte 0x5B is set.
- R9: Offsets that are not implemented, and the unimplemented bytes of 0x80 and 0xD0, read as 0. Writes to them have no effect.
- R10: A write that neither covers a window's enable byte nor touches that window's base dword leaves that window's base and enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword address (byte offset >> 2) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data, little-endian |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| apm_wr | input | 1 | APM control port write strobe |
| apm_data | input | 8 | APM command code |
| pm_base | output | 16 | Power-management window base |
| pm_en | output | 1 | Power-management window enable |
| smb_base | output | 16 | SMBus window base |
| smb_en | output | 1 | SMBus window enable |
| sci_en | output | 1 | ACPI-mode SCI enable bit |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
Two full sweeps cover the APM decoder. Every one of the 256 command codes is sent once with SMI disabled and once with it enabled. The first sweep shows that the code alone never raises an SMI. The second separates the two ACPI codes from all others and tracks sci_en through each transition. All sixteen byte-enable patterns are written to the power-management base dword with distinct data, which tells partial-byte merging and the read-only bit apart from whole-word writes. Writes to the enable bytes with the enable lane off, and writes to unimplemented offsets, show that window outputs move only on a covering write.

// File: rtl/pmcfg_pkg.sv
package pmcfg_pkg;

    localparam int CFG_AW = 6;
    localparam int CFG_DW = 32;
    localparam int CFG_NB = CFG_DW / 8;

    typedef logic [CFG_AW-1:0] cfg_dw_t;

    // dword addresses of the implemented registers
    localparam cfg_dw_t DW_PM_BASE  = 6'h10;  // 0x40
    localparam cfg_dw_t DW_SMM_CTL  = 6'h16;  // 0x58
    localparam cfg_dw_t DW_PM_EN    = 6'h20;  // 0x80, byte lane 0
    localparam cfg_dw_t DW_SMB_BASE = 6'h24;  // 0x90
    localparam cfg_dw_t DW_SMB_EN   = 6'h34;  // 0xD0, byte lane 2

    localparam int SMI_EN_BIT = 25;           // byte 0x5B bit 1

    localparam logic [7:0] APM_CMD_ACPI_ON  = 8'hF1;
    localparam logic [7:0] APM_CMD_ACPI_OFF = 8'hF0;

    typedef struct packed {
        logic [CFG_DW-1:0] pm_base;
        logic [CFG_DW-1:0] smm_ctl;
        logic [7:0]        pm_en;
        logic [CFG_DW-1:0] smb_base;
        logic [7:0]        smb_en;
    } cfg_state_t;

    function automatic logic [CFG_DW-1:0] merge_bytes(
        input logic [CFG_DW-1:0] old_v,
        input logic [CFG_DW-1:0] new_v,
        input logic [CFG_NB-1:0] be
    );
        logic [CFG_DW-1:0] r;
        for (int i = 0; i < CFG_NB; i++) begin
            r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pmcfg_regs.sv
module pmcfg_regs
    import pmcfg_pkg::*;
#(
    parameter bit          SMM_SUPPORTED  = 1'b1,
    parameter logic [15:0] SMB_RESET_BASE = 16'hB100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  cfg_dw_t           cfg_addr,
    input  logic [CFG_NB-1:0] cfg_be,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output cfg_state_t        state_d_o,
    output logic              pm_trig,
    output logic              smb_trig,
    output logic              smi_allowed
);

    localparam logic [CFG_DW-1:0] SMM_RST = SMM_SUPPORTED ? 32'h0 : 32'h0200_0000;
    localparam logic [CFG_DW-1:0] SMB_RST = {16'h0, SMB_RESET_BASE[15:8],
                                             SMB_RESET_BASE[7:1], 1'b1};

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            unique case (cfg_addr)
                DW_PM_BASE:  st_d.pm_base  = merge_bytes(st_q.pm_base, cfg_wdata, cfg_be);
                DW_SMM_CTL:  st_d.smm_ctl  = merge_bytes(st_q.smm_ctl, cfg_wdata, cfg_be);
                DW_SMB_BASE: st_d.smb_base = merge_bytes(st_q.smb_base, cfg_wdata, cfg_be);
                DW_PM_EN:    if (cfg_be[0]) st_d.pm_en  = cfg_wdata[7:0];
                DW_SMB_EN:   if (cfg_be[2]) st_d.smb_en = cfg_wdata[23:16];
                default: ;
            endcase
        end
        st_d.pm_base[0] = 1'b1;   // read-only I/O-space indicator
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pm_base  <= 32'h0000_0001;
            st_q.smm_ctl  <= SMM_RST;
            st_q.pm_en    <= 8'h00;
            st_q.smb_base <= SMB_RST;
            st_q.smb_en   <= 8'h09;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            DW_PM_BASE:  cfg_rdata = st_q.pm_base;
            DW_SMM_CTL:  cfg_rdata = st_q.smm_ctl;
            DW_PM_EN:    cfg_rdata = {24'h0, st_q.pm_en};
            DW_SMB_BASE: cfg_rdata = st_q.smb_base;
            DW_SMB_EN:   cfg_rdata = {8'h0, st_q.smb_en, 16'h0};
            default:     cfg_rdata = '0;
        endcase
    end

    assign state_d_o   = st_d;
    assign pm_trig     = cfg_wr && ((cfg_addr == DW_PM_BASE && |cfg_be) ||
                                    (cfg_addr == DW_PM_EN && cfg_be[0]));
    assign smb_trig    = cfg_wr && ((cfg_addr == DW_SMB_BASE && |cfg_be) ||
                                    (cfg_addr == DW_SMB_EN && cfg_be[2]));
    assign smi_allowed = st_q.smm_ctl[SMI_EN_BIT];

    // R2: an enabled lane of the SMM control dword takes the written byte
    assert_smm_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == DW_SMM_CTL && cfg_be[3])
        |=> st_q.smm_ctl[31:24] == $past(cfg_wdata[31:24]));

    // R3: the indicator bit never reads back as zero
    assert_ro_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == DW_PM_BASE) |-> cfg_rdata[0]);

endmodule

// File: rtl/pmcfg_window.sv
module pmcfg_window
    import pmcfg_pkg::*;
#(
    parameter int                IO_AW     = 16,
    parameter int                ALIGN     = 6,
    parameter logic [CFG_DW-1:0] RST_WORD  = 32'h1,
    parameter logic [7:0]        RST_EN    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [CFG_DW-1:0] base_word,
    input  logic [7:0]        en_byte,
    output logic [IO_AW-1:0]  base_o,
    output logic              en_o
);

    localparam logic [IO_AW-1:0] MASK = {{(IO_AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

    typedef struct packed {
        logic [IO_AW-1:0] base;
        logic             en;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (trig) begin
            w_d.base = base_word[IO_AW-1:0] & MASK;
            w_d.en   = en_byte[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.base <= RST_WORD[IO_AW-1:0] & MASK;
            w_q.en   <= RST_EN[0];
        end else begin
            w_q <= w_d;
        end
    end

    assign base_o = w_q.base;
    assign en_o   = w_q.en;

    // R4: a covering write lands on the next edge
    assert_win_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (base_o == ($past(base_word[IO_AW-1:0]) & MASK)) && (en_o == $past(en_byte[0])));

    // R10: without a covering write the window holds
    assert_win_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(base_o) && $stable(en_o));

endmodule

// File: rtl/pmcfg_apm.sv
module pmcfg_apm
    import pmcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apm_wr,
    input  logic [7:0] apm_data,
    input  logic       smi_allowed,
    output logic       sci_en,
    output logic       smi_pulse
);

    typedef struct packed {
        logic sci;
        logic smi;
    } apm_t;

    apm_t a_d, a_q;
    logic is_acpi_cmd;

    assign is_acpi_cmd = (apm_data == APM_CMD_ACPI_ON) || (apm_data == APM_CMD_ACPI_OFF);

    always_comb begin
        a_d     = a_q;
        a_d.smi = 1'b0;
        if (apm_wr) begin
            if (apm_data == APM_CMD_ACPI_ON)  a_d.sci = 1'b1;
            if (apm_data == APM_CMD_ACPI_OFF) a_d.sci = 1'b0;
            a_d.smi = !is_acpi_cmd && smi_allowed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign sci_en    = a_q.sci;
    assign smi_pulse = a_q.smi;

    // R7: ACPI on/off codes
    assert_sci_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_CMD_ACPI_ON) |=> sci_en && !smi_pulse);
    assert_sci_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_CMD_ACPI_OFF) |=> !sci_en && !smi_pulse);
    assert_sci_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(apm_wr && is_acpi_cmd) |=> $stable(sci_en));

    // R8: an SMI only follows an allowed non-ACPI command, and lasts one cycle
    assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(apm_wr) && !$past(is_acpi_cmd) && $past(smi_allowed));
    assert_smi_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_pulse && !apm_wr) |=> !smi_pulse);

endmodule

// File: rtl/pmcfg_top.sv
module pmcfg_top
    import pmcfg_pkg::*;
#(
    parameter bit          SMM_SUPPORTED  = 1'b1,
    parameter logic [15:0] SMB_RESET_BASE = 16'hB100,
    parameter int          IO_AW          = 16,
    parameter int          WIN_ALIGN      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_NB-1:0] cfg_be,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              apm_wr,
    input  logic [7:0]        apm_data,
    output logic [IO_AW-1:0]  pm_base,
    output logic              pm_en,
    output logic [IO_AW-1:0]  smb_base,
    output logic              smb_en,
    output logic              sci_en,
    output logic              smi_pulse
);

    localparam logic [CFG_DW-1:0] SMB_RST_WORD = {16'h0, SMB_RESET_BASE[15:1], 1'b1};

    cfg_state_t cfg_d;
    logic       pm_trig, smb_trig, smi_allowed;

    pmcfg_regs #(
        .SMM_SUPPORTED (SMM_SUPPORTED),
        .SMB_RESET_BASE(SMB_RESET_BASE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .state_d_o  (cfg_d),
        .pm_trig    (pm_trig),
        .smb_trig   (smb_trig),
        .smi_allowed(smi_allowed)
    );

    pmcfg_window #(
        .IO_AW   (IO_AW),
        .ALIGN   (WIN_ALIGN),
        .RST_WORD(32'h0000_0001),
        .RST_EN  (8'h00)
    ) u_pm_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (pm_trig),
        .base_word(cfg_d.pm_base),
        .en_byte  (cfg_d.pm_en),
        .base_o   (pm_base),
        .en_o     (pm_en)
    );

    pmcfg_window #(
        .IO_AW   (IO_AW),
        .ALIGN   (WIN_ALIGN),
        .RST_WORD(SMB_RST_WORD),
        .RST_EN  (8'h09)
    ) u_smb_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (smb_trig),
        .base_word(cfg_d.smb_base),
        .en_byte  (cfg_d.smb_en),
        .base_o   (smb_base),
        .en_o     (smb_en)
    );

    pmcfg_apm u_apm (
        .clk        (clk),
        .rst_n      (rst_n),
        .apm_wr     (apm_wr),
        .apm_data   (apm_data),
        .smi_allowed(smi_allowed),
        .sci_en     (sci_en),
        .smi_pulse  (smi_pulse)
    );

endmodule

// File: tb/pmcfg_top_test.sv
`timescale 1ns/1ps
module pmcfg_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_data = '0;

    logic [31:0] rdata, rdata_n;
    logic [15:0] pm_base, smb_base, pm_base_n, smb_base_n;
    logic        pm_en, smb_en, sci_en, smi_pulse;
    logic        pm_en_n, smb_en_n, sci_en_n, smi_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    pmcfg_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata),
        .apm_wr(apm_wr), .apm_data(apm_data), .pm_base(pm_base), .pm_en(pm_en),
        .smb_base(smb_base), .smb_en(smb_en), .sci_en(sci_en), .smi_pulse(smi_pulse)
    );

    pmcfg_top #(.SMM_SUPPORTED(1'b0)) uut_nosmm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_n),
        .apm_wr(apm_wr), .apm_data(apm_data), .pm_base(pm_base_n), .pm_en(pm_en_n),
        .smb_base(smb_base_n), .smb_en(smb_en_n), .sci_en(sci_en_n), .smi_pulse(smi_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #0.5;
        d = rdata;
    endtask

    // drives one APM write; returns smi seen in the cycle after, and after that
    task automatic apm_cmd(input logic [7:0] code, output logic smi1, output logic smi2);
        @(negedge clk);
        apm_wr = 1'b1; apm_data = code;
        @(negedge clk);
        apm_wr = 1'b0;
        smi1 = smi_pulse;
        @(negedge clk);
        smi2 = smi_pulse;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? n[i*8 +: 8] : o[i*8 +: 8];
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, model;
        logic        s1, s2, sci_m;
        logic [15:0] pb_save;
        logic        pe_save;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cfg_read(6'h10, rd); check("R1 pm base dword", rd, 32'h0000_0001);
        cfg_read(6'h16, rd); check("R1 smm dword", rd, 32'h0);
        cfg_read(6'h20, rd); check("R1 pm en dword", rd, 32'h0);
        cfg_read(6'h24, rd); check("R1 smb base dword", rd, 32'h0000_B101);
        cfg_read(6'h34, rd); check("R1 smb en dword", rd, 32'h0009_0000);
        check("R1 pm_base", pm_base, 16'h0);
        check("R1 pm_en", pm_en, 0);
        check("R1 smb_base", smb_base, 16'hB100);
        check("R1 smb_en", smb_en, 1);
        check("R1 sci_en", sci_en, 0);
        check("R1 smi", smi_pulse, 0);

        // R6: no SMM support -> 0x5B = 0x02
        cfg_addr = 6'h16; #0.5;
        check("R6 smm dword nosmm", rdata_n, 32'h0200_0000);

        // R8: strap-off instance raises SMI, SMM-capable one does not
        @(negedge clk);
        apm_wr = 1'b1; apm_data = 8'h55;
        @(negedge clk);
        apm_wr = 1'b0;
        check("R8 nosmm smi pulse", smi_n, 1);
        check("R8 smm-disabled no smi", smi_pulse, 0);
        @(negedge clk);
        check("R8 nosmm pulse one cycle", smi_n, 0);

        // R2 R3 R4: sweep every byte-enable pattern on the PM base dword
        model = 32'h0000_0001;
        for (int be = 0; be < 16; be++) begin
            logic [31:0] d;
            d = {be[3:0], 4'h3, 8'h5A ^ be[7:0], 8'hC7 + be[7:0], be[3:0], 4'hE};
            cfg_write(6'h10, be[3:0], d);
            model = merge(model, d, be[3:0]) | 32'h1;
            cfg_read(6'h10, rd);
            check("R2 R3 pm base readback", rd, model);
            check("R4 pm_base after write", pm_base, model[15:0] & 16'hFFC0);
            check("R4 pm_en unaffected", pm_en, 0);
        end
        cfg_write(6'h10, 4'hF, 32'h0000_0000);
        cfg_read(6'h10, rd);
        check("R3 bit0 stays 1", rd, 32'h1);

        // R4: enable byte
        cfg_write(6'h10, 4'h3, 32'h0000_1234);
        cfg_write(6'h20, 4'h1, 32'h0000_0001);
        check("R4 pm_en set", pm_en, 1);
        check("R4 pm_base value", pm_base, 16'h1200);
        cfg_write(6'h20, 4'hE, 32'hFFFF_FF00);
        check("R4 pm_en lane0 off no change", pm_en, 1);
        cfg_read(6'h20, rd);
        check("R9 pm en upper bytes read 0", rd, 32'h0000_0001);
        cfg_write(6'h20, 4'h1, 32'h0000_00FE);
        check("R4 pm_en cleared", pm_en, 0);

        // R5: SMBus window
        cfg_write(6'h24, 4'hF, 32'h1234_5678);
        check("R5 smb_base", smb_base, 16'h5640);
        cfg_read(6'h24, rd);
        check("R5 smb base readback", rd, 32'h1234_5678);
        cfg_write(6'h34, 4'h4, 32'h0000_0000);
        check("R5 smb_en cleared", smb_en, 0);
        cfg_write(6'h34, 4'hB, 32'hFFFF_FFFF);
        check("R5 smb_en lane2 off no change", smb_en, 0);
        cfg_write(6'h34, 4'h4, 32'h0001_0000);
        check("R5 smb_en set", smb_en, 1);
        cfg_write(6'h24, 4'h2, 32'h0000_A700);
        check("R5 smb_base partial", smb_base, 16'hA740);

        // R9 R10: unimplemented offsets and foreign writes
        pb_save = pm_base; pe_save = pm_en;
        for (int a = 0; a < 64; a++) begin
            if (a != 6'h10 && a != 6'h16 && a != 6'h20 && a != 6'h24 && a != 6'h34) begin
                cfg_write(a[5:0], 4'hF, 32'hFFFF_FFFF);
                cfg_read(a[5:0], rd);
                check("R9 unimplemented reads 0", rd, 32'h0);
            end
        end
        check("R10 pm_base held", pm_base, pb_save);
        check("R10 pm_en held", pm_en, pe_save);
        check("R10 smb_base held", smb_base, 16'hA740);
        check("R10 smb_en held", smb_en, 1);
        cfg_write(6'h24, 4'hF, 32'h0000_2000);
        check("R10 pm_base held on smb write", pm_base, pb_save);

        // R7 R8: full APM sweep with SMI disabled
        sci_m = 1'b0;
        for (int c = 0; c < 256; c++) begin
            apm_cmd(c[7:0], s1, s2);
            if (c == 8'hF1) sci_m = 1'b1;
            if (c == 8'hF0) sci_m = 1'b0;
            check("R8 no smi when disabled", s1, 0);
            check("R7 sci tracking", sci_en, sci_m);
        end

        // R2 R8: enable SMI through byte 0x5B, then sweep again
        cfg_write(6'h16, 4'h8, 32'h0200_0000);
        cfg_read(6'h16, rd);
        check("R2 smm ctl lane3", rd, 32'h0200_0000);
        for (int c = 0; c < 256; c++) begin
            logic exp;
            exp = !(c == 8'hF0 || c == 8'hF1);
            apm_cmd(c[7:0], s1, s2);
            if (c == 8'hF1) sci_m = 1'b1;
            if (c == 8'hF0) sci_m = 1'b0;
            check("R8 smi pulse", s1, exp);
            check("R8 smi single cycle", s2, 0);
            check("R7 sci tracking enabled", sci_en, sci_m);
        end
        apm_cmd(8'hF1, s1, s2);
        check("R7 F1 sets sci", sci_en, 1);
        apm_cmd(8'h20, s1, s2);
        check("R7 other code keeps sci", sci_en, 1);
        apm_cmd(8'hF0, s1, s2);
        check("R7 F0 clears sci", sci_en, 0);
        check("R7 F0 no smi", s1, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule